// File: doc/BRIEF.md
# Occupancy-Driven Issue Queue Resizer

This controller decides how many equal-sized partitions of an out-of-order issue queue are switched on. It watches the per-entry valid bits of the queue and a per-cycle strobe raised whenever dispatch had to stall. From these inputs it produces a partition-enable mask that the queue storage and its power gating use. It does not hold the queue itself.

Occupancy is sampled at a short, power-of-two interval. Only the entries of partitions that are enabled count toward a sample. The samples are summed over a longer power-of-two update window, and the mean is found with a right shift. At the end of the window, the controller compares the mean with the enabled capacity. If at least one whole partition is idle on average, it shrinks the queue, either by a single partition or by every idle partition, depending on a static mode input. The queue grows by one partition as soon as the dispatch stalls counted in the current window reach a threshold. A growth event restarts the window and throws away the samples gathered so far.

Every pin is plain control or status. No stream handshake is present, because the block consumes a snapshot every cycle and emits a level, not a sequence of items. The sample and update window sizes (as log2 values), the stall threshold and the shrink mode are static configuration inputs, with the sample log2 no larger than the update log2.

Top module: `iq_resize_ctrl`

## Requirements
- R1: After reset, all NUM_PARTS partitions are enabled: `cur_parts` equals NUM_PARTS and every bit of `part_en` is 1.
- R2: `part_en` is always a contiguous run of ones starting at bit 0, and the number of ones equals `cur_parts`, which stays within 1 to NUM_PARTS.
- R3: A sample counts the valid bits of enabled partitions only. Partition p covers entries p*PART_ENTRIES to p*PART_ENTRIES+PART_ENTRIES-1. Valid bits in disabled partitions have no effect on any decision. A sample is taken in every window cycle whose index has its low `cfg_sample_lg2` bits all set.
- R4: The window cycle index runs from 0 to 2^`cfg_update_lg2`-1. On the last cycle, the mean occupancy is the sum of all samples in the window, including the one taken on that cycle, shifted right by `cfg_update_lg2`-`cfg_sample_lg2`.
- R5: The size changes only at a window end or on a growth event. At a window end, if the enabled entries minus the mean is less than PART_ENTRIES, the size is held.
- R6: With `cfg_aggressive`=0, a window end whose slack (enabled entries minus mean) is at least PART_ENTRIES removes exactly one partition.
- R7: With `cfg_aggressive`=1, a window end removes floor(slack / PART_ENTRIES) partitions, never going below 1 partition.
- R8: On the cycle where `dispatch_stall` is high and the stall count of the current window (including that cycle) reaches `cfg_stall_limit`, the size grows by one partition, saturating at NUM_PARTS. The new size is visible after that clock edge.
- R9: A growth event resets the window index, the sample sum and the stall count. The next window end then comes a full 2^`cfg_update_lg2` cycles later, and earlier samples are discarded. If growth and a window end fall on the same cycle, growth wins and no shrink happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_valid | input | NUM_PARTS*PART_ENTRIES | Valid bit of every queue entry |
| dispatch_stall | input | 1 | High in each cycle dispatch was blocked |
| cfg_aggressive | input | 1 | 0 removes one partition per shrink, 1 removes all idle ones |
| cfg_sample_lg2 | input | $clog2(LG2_MAX+1) | log2 of the sample interval |
| cfg_update_lg2 | input | $clog2(LG2_MAX+1) | log2 of the update window |
| cfg_stall_limit | input | LG2_MAX+1 | Stall count that triggers growth |
| part_en | output | NUM_PARTS | Enable for each partition, low bits first |
| cur_parts | output | $clog2(NUM_PARTS+1) | Number of enabled partitions |

## Verification
Two actions can fall on the same clock: the growth triggered by the stall count, and the shrink decision on the window's last cycle. The bench sets the stall threshold to one, keeps the queue empty so that a shrink would be due, and raises a single stall exactly on the last window cycle. The check passes when the size rises instead of falling, the size holds through the following 63 cycles, and the next shrink arrives only after a complete fresh window. A second case grows the queue in the middle of a busy window and then checks that the shrink at the next window end uses only the samples taken after the restart.

// File: rtl/rsz_pkg.sv
`timescale 1ns/1ps
package rsz_pkg;
  typedef enum logic {
    SHRINK_ONE = 1'b0,
    SHRINK_FIT = 1'b1
  } shrink_mode_e;
endpackage

// File: rtl/rsz_occupancy.sv
`timescale 1ns/1ps
module rsz_occupancy #(
  parameter int PART_ENTRIES = 8,
  parameter int NUM_PARTS    = 8,
  parameter int OCC_W        = 7
) (
  input  logic [NUM_PARTS*PART_ENTRIES-1:0] entry_valid,
  input  logic [NUM_PARTS-1:0]              part_en,
  output logic [OCC_W-1:0]                  occ
);
  localparam int PC_W = $clog2(PART_ENTRIES + 1);

  logic [PC_W-1:0] gated [NUM_PARTS];

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    logic [PC_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = 0; j < PART_ENTRIES; j++)
        cnt = cnt + PC_W'(entry_valid[p*PART_ENTRIES + j]);
    end
    assign gated[p] = part_en[p] ? cnt : '0;
  end

  always_comb begin
    occ = '0;
    for (int p = 0; p < NUM_PARTS; p++)
      occ = occ + OCC_W'(gated[p]);
  end
endmodule

// File: rtl/rsz_window.sv
`timescale 1ns/1ps
module rsz_window #(
  parameter int LG2_MAX = 16,
  parameter int LGW     = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LGW-1:0] cfg_sample_lg2,
  input  logic [LGW-1:0] cfg_update_lg2,
  input  logic           restart,
  output logic           sample_tick,
  output logic           window_end
);
  localparam int CNT_W = LG2_MAX;
  localparam logic [CNT_W-1:0] ONES   = '1;
  localparam logic [LGW-1:0]   CNT_LG = LGW'(CNT_W);

  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] smask, umask;

  always_comb begin
    smask       = ONES >> (CNT_LG - cfg_sample_lg2);
    umask       = ONES >> (CNT_LG - cfg_update_lg2);
    sample_tick = (cyc & smask) == smask;
    window_end  = (cyc == umask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cyc <= '0;
    else if (restart) cyc <= '0;
    else              cyc <= cyc + CNT_W'(1);
  end

  AST_RESTART_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && cfg_update_lg2 != '0) |=> !window_end); // R9
  AST_END_IS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (window_end && cfg_sample_lg2 <= cfg_update_lg2) |-> sample_tick); // R4
endmodule

// File: rtl/rsz_accum.sv
`timescale 1ns/1ps
module rsz_accum #(
  parameter int ACC_W   = 23,
  parameter int OCC_W   = 7,
  parameter int STALL_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_tick,
  input  logic [OCC_W-1:0]   occ,
  input  logic               stall_in,
  input  logic [STALL_W-1:0] stall_limit,
  input  logic               clear,
  output logic [ACC_W-1:0]   sum_total,
  output logic               stall_hit
);
  logic [ACC_W-1:0]   acc;
  logic [STALL_W-1:0] stall_cnt;
  logic [STALL_W:0]   cnt_inc;

  always_comb begin
    sum_total = acc + (sample_tick ? ACC_W'(occ) : '0);
    cnt_inc   = {1'b0, stall_cnt} + {{STALL_W{1'b0}}, 1'b1};
    stall_hit = stall_in && (cnt_inc >= {1'b0, stall_limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      stall_cnt <= '0;
    end else if (clear) begin
      acc       <= '0;
      stall_cnt <= '0;
    end else begin
      acc       <= sum_total;
      stall_cnt <= stall_cnt + STALL_W'(stall_in);
    end
  end

  AST_STALL_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !stall_in) |=> $stable(stall_cnt)); // R8
endmodule

// File: rtl/rsz_size_ctrl.sv
`timescale 1ns/1ps
module rsz_size_ctrl
  import rsz_pkg::*;
#(
  parameter int PART_ENTRIES = 8,
  parameter int NUM_PARTS    = 8,
  parameter int PARTS_W      = 4,
  parameter int ACC_W        = 23,
  parameter int LGW          = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_aggressive,
  input  logic [LGW-1:0]     avg_shift,
  input  logic [ACC_W-1:0]   sum_total,
  input  logic               window_end,
  input  logic               stall_hit,
  output logic               restart,
  output logic [PARTS_W-1:0] cur_parts,
  output logic [NUM_PARTS-1:0] part_en
);
  shrink_mode_e       mode;
  logic [ACC_W-1:0]   avg, cur_entries, diff, drop;
  logic [PARTS_W-1:0] shrunk, grown, nxt;

  always_comb begin
    mode        = shrink_mode_e'(cfg_aggressive);
    avg         = sum_total >> avg_shift;
    cur_entries = ACC_W'(cur_parts) * ACC_W'(PART_ENTRIES);
    diff        = (cur_entries > avg) ? cur_entries - avg : '0;
    if (mode == SHRINK_FIT)
      drop = diff / ACC_W'(PART_ENTRIES);
    else
      drop = (diff >= ACC_W'(PART_ENTRIES)) ? ACC_W'(1) : '0;
    if (drop >= ACC_W'(cur_parts)) shrunk = PARTS_W'(1);
    else                           shrunk = cur_parts - PARTS_W'(drop);
    grown = (cur_parts >= PARTS_W'(NUM_PARTS)) ? cur_parts : cur_parts + PARTS_W'(1);
    if (stall_hit)       nxt = grown;
    else if (window_end) nxt = shrunk;
    else                 nxt = cur_parts;
    restart = stall_hit | window_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_parts <= PARTS_W'(NUM_PARTS);
    else        cur_parts <= nxt;
  end

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_en
    assign part_en[p] = (PARTS_W'(p) < cur_parts);
  end

  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_parts >= PARTS_W'(1)) && (cur_parts <= PARTS_W'(NUM_PARTS))); // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_end && !stall_hit) |=> $stable(cur_parts)); // R5
  AST_GROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_hit && cur_parts < PARTS_W'(NUM_PARTS)) |=> cur_parts == $past(cur_parts) + PARTS_W'(1)); // R8
  AST_GROW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_hit && cur_parts == PARTS_W'(NUM_PARTS)) |=> cur_parts == PARTS_W'(NUM_PARTS)); // R8
  AST_CONS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (window_end && !stall_hit && !cfg_aggressive) |=>
      (cur_parts == $past(cur_parts) || cur_parts == $past(cur_parts) - PARTS_W'(1))); // R6
  AST_SHRINK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (window_end && !stall_hit) |=> cur_parts <= $past(cur_parts)); // R7
endmodule

// File: rtl/iq_resize_ctrl.sv
`timescale 1ns/1ps
module iq_resize_ctrl #(
  parameter int PART_ENTRIES = 8,
  parameter int NUM_PARTS    = 8,
  parameter int LG2_MAX      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_PARTS*PART_ENTRIES-1:0]     entry_valid,
  input  logic                                  dispatch_stall,
  input  logic                                  cfg_aggressive,
  input  logic [$clog2(LG2_MAX+1)-1:0]          cfg_sample_lg2,
  input  logic [$clog2(LG2_MAX+1)-1:0]          cfg_update_lg2,
  input  logic [LG2_MAX:0]                      cfg_stall_limit,
  output logic [NUM_PARTS-1:0]                  part_en,
  output logic [$clog2(NUM_PARTS+1)-1:0]        cur_parts
);
  localparam int ENTRIES = NUM_PARTS * PART_ENTRIES;
  localparam int OCC_W   = $clog2(ENTRIES + 1);
  localparam int PARTS_W = $clog2(NUM_PARTS + 1);
  localparam int LGW     = $clog2(LG2_MAX + 1);
  localparam int ACC_W   = LG2_MAX + OCC_W;
  localparam int STALL_W = LG2_MAX + 1;

  logic [OCC_W-1:0] occ;
  logic             sample_tick, window_end, restart, stall_hit;
  logic [ACC_W-1:0] sum_total;
  logic [LGW-1:0]   avg_shift;

  assign avg_shift = cfg_update_lg2 - cfg_sample_lg2;

  rsz_occupancy #(.PART_ENTRIES(PART_ENTRIES), .NUM_PARTS(NUM_PARTS), .OCC_W(OCC_W)) u_occ (
    .entry_valid (entry_valid),
    .part_en     (part_en),
    .occ         (occ)
  );

  rsz_window #(.LG2_MAX(LG2_MAX), .LGW(LGW)) u_win (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_sample_lg2 (cfg_sample_lg2),
    .cfg_update_lg2 (cfg_update_lg2),
    .restart        (restart),
    .sample_tick    (sample_tick),
    .window_end     (window_end)
  );

  rsz_accum #(.ACC_W(ACC_W), .OCC_W(OCC_W), .STALL_W(STALL_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .occ         (occ),
    .stall_in    (dispatch_stall),
    .stall_limit (cfg_stall_limit),
    .clear       (restart),
    .sum_total   (sum_total),
    .stall_hit   (stall_hit)
  );

  rsz_size_ctrl #(
    .PART_ENTRIES(PART_ENTRIES), .NUM_PARTS(NUM_PARTS), .PARTS_W(PARTS_W),
    .ACC_W(ACC_W), .LGW(LGW)
  ) u_size (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_aggressive (cfg_aggressive),
    .avg_shift      (avg_shift),
    .sum_total      (sum_total),
    .window_end     (window_end),
    .stall_hit      (stall_hit),
    .restart        (restart),
    .cur_parts      (cur_parts),
    .part_en        (part_en)
  );

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (((part_en >> 1) & ~part_en) == '0) && part_en[0]); // R2
  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(part_en) == int'(cur_parts)); // R2
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= $countones(part_en) * PART_ENTRIES); // R3
endmodule

// File: tb/tb_iq_resize_ctrl.sv
`timescale 1ns/1ps
module tb_iq_resize_ctrl;
  localparam int PE = 8;
  localparam int NP = 8;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [63:0] valid;
  logic        stall;
  logic        aggr;
  logic [4:0]  slg, ulg;
  logic [16:0] lim;
  logic [7:0]  part_en;
  logic [3:0]  cur_parts;

  iq_resize_ctrl dut (
    .clk(clk), .rst_n(rst_n), .entry_valid(valid), .dispatch_stall(stall),
    .cfg_aggressive(aggr), .cfg_sample_lg2(slg), .cfg_update_lg2(ulg),
    .cfg_stall_limit(lim), .part_en(part_en), .cur_parts(cur_parts)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int m_cyc, m_acc, m_stall, m_parts;
  int    exp_q[$];
  string tag_q[$];
  int    mon_e;
  string mon_t;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mask_of(input int p);
    return (1 << p) - 1;
  endfunction

  // reference model, one clock per call; pushes the size expected after the edge
  task automatic step(input string tag);
    int smask, umask, occ, tot, avg, diff, drop, np;
    bit samp, fin, grow;
    smask = (1 << slg) - 1;
    umask = (1 << ulg) - 1;
    occ = 0;
    for (int i = 0; i < m_parts * PE; i++) occ += int'(valid[i]);
    samp = ((m_cyc & smask) == smask);
    fin  = (m_cyc == umask);
    grow = stall && (m_stall + 1 >= int'(lim));
    if (grow) begin
      if (m_parts < NP) m_parts++;
      m_cyc = 0; m_acc = 0; m_stall = 0;
    end else if (fin) begin
      tot  = m_acc + (samp ? occ : 0);
      avg  = tot >> (ulg - slg);
      diff = (m_parts * PE > avg) ? m_parts * PE - avg : 0;
      drop = aggr ? diff / PE : (diff >= PE ? 1 : 0);
      np   = m_parts - drop;
      m_parts = (np < 1) ? 1 : np;
      m_cyc = 0; m_acc = 0; m_stall = 0;
    end else begin
      m_cyc++;
      m_acc += samp ? occ : 0;
      m_stall += int'(stall);
    end
    exp_q.push_back(m_parts);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = '0; stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cyc = 0; m_acc = 0; m_stall = 0; m_parts = NP;
  endtask

  // monitor: pops the scoreboard after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      check({mon_t, " size"}, int'(cur_parts), mon_e);
      check({"R2 mask ", mon_t}, int'(part_en), mask_of(mon_e));
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    slg = 5'd2; ulg = 5'd6; lim = 17'd1000; aggr = 1'b0;
    do_reset();
    check("R1 reset size", int'(cur_parts), 8);
    check("R1 reset mask", int'(part_en), 255);

    // R5: full queue, no slack
    valid = '1;
    run(63, "R5");
    check("R5 mid window", int'(cur_parts), 8);
    run(1, "R5");
    check("R5 busy window holds", int'(cur_parts), 8);

    // R6: empty queue, conservative
    valid = '0;
    run(63, "R6");
    check("R5 no change before window end", int'(cur_parts), 8);
    run(1, "R6");
    check("R6 one partition removed", int'(cur_parts), 7);

    // R7: aggressive, empty, clamps at one
    aggr = 1'b1;
    run(64, "R7");
    check("R7 aggressive clamp", int'(cur_parts), 1);

    // R8: growth on stall threshold
    lim = 17'd4;
    stall = 1'b1; run(3, "R8");
    check("R8 below threshold", int'(cur_parts), 1);
    run(1, "R8");
    check("R8 grow at threshold", int'(cur_parts), 2);
    run(4, "R8");
    stall = 1'b0;
    check("R8 second growth", int'(cur_parts), 3);

    // R3: valid bits only in disabled partitions
    valid = ~64'hFF_FFFF;
    run(64, "R3");
    check("R3 disabled entries ignored", int'(cur_parts), 1);

    // R8 saturation
    valid = '0; stall = 1'b1;
    run(28, "R8");
    check("R8 grown to max", int'(cur_parts), 8);
    run(4, "R8");
    stall = 1'b0;
    check("R8 saturate at max", int'(cur_parts), 8);

    // R4: half-busy window, mean 20, slack 44 -> drop 5
    valid = 64'hFF_FFFF_FFFF;
    run(32, "R4");
    valid = '0;
    run(32, "R4");
    check("R4 averaged shrink", int'(cur_parts), 3);

    // R9: growth and window end on the same cycle
    aggr = 1'b0; lim = 17'd1;
    run(63, "R9");
    stall = 1'b1; run(1, "R9"); stall = 1'b0;
    check("R9 growth beats shrink", int'(cur_parts), 4);
    run(63, "R9");
    check("R9 window restarted", int'(cur_parts), 4);
    run(1, "R9");
    check("R9 shrink after full window", int'(cur_parts), 3);

    // R9: samples before growth discarded
    aggr = 1'b1; valid = '1;
    run(40, "R9");
    stall = 1'b1; run(1, "R9"); stall = 1'b0;
    check("R9 mid-window growth", int'(cur_parts), 4);
    valid = '0;
    run(64, "R9");
    check("R9 old samples discarded", int'(cur_parts), 1);

    // default-sized windows
    slg = 5'd4; ulg = 5'd11; lim = 17'd512; aggr = 1'b0;
    do_reset();
    check("R1 second reset", int'(cur_parts), 8);
    run(2047, "R5");
    check("R5 long window hold", int'(cur_parts), 8);
    run(1, "R6");
    check("R6 long window shrink", int'(cur_parts), 7);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule